// File: doc/BRIEF.md
# Dual-Direction Processor Mailbox

Two processors that share one clock exchange 32-bit words through this block. Each processor sees its own small register window with three registers: a control/status word, an outbound data register and an inbound data register. A word that one side writes to its outbound register goes into a queue. The opposite side drains that queue through its inbound register, in the order the words were written. There is one such queue for each direction.

The control word of each side reports two things: the fill state of the queue that side feeds, and the fill state of the queue it drains. It also holds two interrupt enables, a flush command for the outbound queue, a sticky error flag and a channel enable. Each side drives two level interrupts. One says that its outbound queue has run dry. The other says that its inbound queue holds data.

Register addresses (2-bit `xAddr`): 0 is the control word, 1 is the outbound data register (a write pushes), and 2 is the inbound data register (a read with `xRdEn` pops). Read data is combinational from the address.

Top module: `ipc_mailbox`

## Requirements
- R1: Control bit 0 reads 1 when the local outbound queue is empty. Bit 1 reads 1 when that queue holds 16 words.
- R2: Control bit 2 is an enable. The outbound-empty interrupt output equals bit 2 AND outbound-empty.
- R3: Writing a control word with bit 3 set empties the local outbound queue. A control write with bit 3 clear leaves the queue untouched. Bit 3 reads as 0.
- R4: Control bits 8 and 9 report empty and full for the inbound queue, which is the opposite side's outbound queue.
- R5: Control bit 10 is an enable. The inbound-data interrupt output equals bit 10 AND (inbound queue not empty).
- R6: Words pushed on one side are read on the other side in the same order, with all 32 bits intact.
- R7: A push into a full queue discards the word, leaves the queue unchanged and sets control bit 14.
- R8: A pop from an empty inbound queue returns the last word popped on that side (0 after reset), changes no queue state and sets control bit 14.
- R9: Bit 14 stays set until a control write with bit 14 equal to 1. A control write with bit 14 equal to 0 leaves it set.
- R10: Control bit 15 enables the side. While it is 0, that side's pushes and pops have no effect on either queue.
- R11: After reset, both queues are empty and every enable and the error flag are 0. Each control word reads 0x00000101 and all interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Active-low synchronous reset |
| aWrEn | input | 1 | Side A register write strobe |
| aRdEn | input | 1 | Side A register read strobe (pops at address 2) |
| aAddr | input | 2 | Side A register address |
| aWrData | input | 32 | Side A write data |
| aRdData | output | 32 | Side A read data |
| aIrqSendEmpty | output | 1 | Side A outbound-empty interrupt |
| aIrqRecvNotEmpty | output | 1 | Side A inbound-data interrupt |
| bWrEn | input | 1 | Side B register write strobe |
| bRdEn | input | 1 | Side B register read strobe (pops at address 2) |
| bAddr | input | 2 | Side B register address |
| bWrData | input | 32 | Side B write data |
| bRdData | output | 32 | Side B read data |
| bIrqSendEmpty | output | 1 | Side B outbound-empty interrupt |
| bIrqRecvNotEmpty | output | 1 | Side B inbound-data interrupt |

## Verification
A queue pointer or count that has gone wrong shows at the ports as early as the next clock edge. The empty and full bits on both sides stop matching the number of words written and read, and the interrupt levels that follow those bits change at the same edge. A storage or read-pointer fault shows only when the word is drained: the opposite side gets a word out of order or with the wrong value, so the bench compares every popped word against the sequence that was pushed. A wrong error or enable register shows at the very next read of the control word.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] REG_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] REG_SEND = 2'd1;
  localparam logic [ADDR_W-1:0] REG_RECV = 2'd2;

  // control word bit positions
  localparam int B_TX_EMPTY  = 0;
  localparam int B_TX_FULL   = 1;
  localparam int B_TX_IRQEN  = 2;
  localparam int B_TX_FLUSH  = 3;
  localparam int B_RX_EMPTY  = 8;
  localparam int B_RX_FULL   = 9;
  localparam int B_RX_IRQEN  = 10;
  localparam int B_ERR       = 14;
  localparam int B_EN        = 15;
  localparam int CTRL_W      = 16;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } mboxStb_t;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushStb,
  input  logic             popStb,
  input  logic             flushStb,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] popData,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [WIDTH-1:0] lastPop;
  logic             doPush, doPop;

  assign empty = (count == '0);
  assign full  = (count == CNT_MAX);

  always_comb begin
    doPush = pushStb && !full && !flushStb;
    doPop  = popStb && !empty && !flushStb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      lastPop <= '0;
    end else if (flushStb) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop) begin
        rdPtr   <= rdPtr + 1'b1;
        lastPop <= mem[rdPtr];
      end
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  assign popData = empty ? lastPop : mem[rdPtr];
endmodule

// File: rtl/mbox_side_ctrl.sv
module mbox_side_ctrl
  import ipc_mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txEmpty,
  input  logic              txFull,
  input  logic              rxEmpty,
  input  logic              rxFull,
  input  logic [DATA_W-1:0] rxData,
  output mboxStb_t          stb,
  output logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqSendEmpty,
  output logic              irqRecvNotEmpty
);
  logic enable, txIrqEn, rxIrqEn, errFlag;
  logic ctrlWr, errSet;
  logic [CTRL_W-1:0] ctrlWord;

  assign ctrlWr    = wrEn && (addr == REG_CTRL);
  assign stb.push  = enable && wrEn && (addr == REG_SEND);
  assign stb.pop   = enable && rdEn && (addr == REG_RECV);
  assign stb.flush = ctrlWr && wrData[B_TX_FLUSH];
  assign pushData  = wrData;
  assign errSet    = (stb.push && txFull) || (stb.pop && rxEmpty);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable  <= 1'b0;
      txIrqEn <= 1'b0;
      rxIrqEn <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enable  <= wrData[B_EN];
        txIrqEn <= wrData[B_TX_IRQEN];
        rxIrqEn <= wrData[B_RX_IRQEN];
      end
      if (errSet) errFlag <= 1'b1;
      else if (ctrlWr && wrData[B_ERR]) errFlag <= 1'b0;
    end
  end

  always_comb begin
    ctrlWord             = '0;
    ctrlWord[B_TX_EMPTY] = txEmpty;
    ctrlWord[B_TX_FULL]  = txFull;
    ctrlWord[B_TX_IRQEN] = txIrqEn;
    ctrlWord[B_RX_EMPTY] = rxEmpty;
    ctrlWord[B_RX_FULL]  = rxFull;
    ctrlWord[B_RX_IRQEN] = rxIrqEn;
    ctrlWord[B_ERR]      = errFlag;
    ctrlWord[B_EN]       = enable;
  end

  always_comb begin
    case (addr)
      REG_CTRL: rdData = DATA_W'(ctrlWord);
      REG_RECV: rdData = rxData;
      default:  rdData = '0;
    endcase
  end

  assign irqSendEmpty    = txIrqEn && txEmpty;
  assign irqRecvNotEmpty = rxIrqEn && !rxEmpty;
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aWrEn,
  input  logic              aRdEn,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWrData,
  output logic [DATA_W-1:0] aRdData,
  output logic              aIrqSendEmpty,
  output logic              aIrqRecvNotEmpty,
  input  logic              bWrEn,
  input  logic              bRdEn,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWrData,
  output logic [DATA_W-1:0] bRdData,
  output logic              bIrqSendEmpty,
  output logic              bIrqRecvNotEmpty
);
  mboxStb_t aStb, bStb;
  logic [DATA_W-1:0] aPushData, bPushData, abPopData, baPopData;
  logic abEmpty, abFull, baEmpty, baFull;

  mbox_side_ctrl #(.DATA_W(DATA_W)) u_ctrlA (
    .clk(clk), .rstN(rstN), .wrEn(aWrEn), .rdEn(aRdEn), .addr(aAddr),
    .wrData(aWrData), .txEmpty(abEmpty), .txFull(abFull),
    .rxEmpty(baEmpty), .rxFull(baFull), .rxData(baPopData),
    .stb(aStb), .pushData(aPushData), .rdData(aRdData),
    .irqSendEmpty(aIrqSendEmpty), .irqRecvNotEmpty(aIrqRecvNotEmpty)
  );

  mbox_side_ctrl #(.DATA_W(DATA_W)) u_ctrlB (
    .clk(clk), .rstN(rstN), .wrEn(bWrEn), .rdEn(bRdEn), .addr(bAddr),
    .wrData(bWrData), .txEmpty(baEmpty), .txFull(baFull),
    .rxEmpty(abEmpty), .rxFull(abFull), .rxData(abPopData),
    .stb(bStb), .pushData(bPushData), .rdData(bRdData),
    .irqSendEmpty(bIrqSendEmpty), .irqRecvNotEmpty(bIrqRecvNotEmpty)
  );

  mbox_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_fifoAB (
    .clk(clk), .rstN(rstN), .pushStb(aStb.push), .popStb(bStb.pop),
    .flushStb(aStb.flush), .pushData(aPushData), .popData(abPopData),
    .empty(abEmpty), .full(abFull)
  );

  mbox_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_fifoBA (
    .clk(clk), .rstN(rstN), .pushStb(bStb.push), .popStb(aStb.pop),
    .flushStb(bStb.flush), .pushData(bPushData), .popData(baPopData),
    .empty(baEmpty), .full(baFull)
  );
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker (
  input logic clk,
  input logic rstN,
  input logic abEmpty,
  input logic abFull,
  input logic baEmpty,
  input logic aFlush,
  input logic bPop,
  input logic aIrqSendEmpty,
  input logic aIrqRecvNotEmpty
);
  AST_NOT_EMPTY_AND_FULL: assert property (@(posedge clk) disable iff (!rstN)
    !(abEmpty && abFull)); // R1

  AST_SEND_IRQ_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    aIrqSendEmpty |-> abEmpty); // R2

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    aFlush |=> abEmpty); // R3

  AST_RECV_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    aIrqRecvNotEmpty |-> !baEmpty); // R5

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (abFull && !bPop && !aFlush) |=> abFull); // R7
endmodule

bind ipc_mailbox mbox_checker u_chk (
  .clk(clk), .rstN(rstN), .abEmpty(abEmpty), .abFull(abFull),
  .baEmpty(baEmpty), .aFlush(aStb.flush), .bPop(bStb.pop),
  .aIrqSendEmpty(aIrqSendEmpty), .aIrqRecvNotEmpty(aIrqRecvNotEmpty)
);

// File: tb/ipc_mailbox_bench.sv
module ipc_mailbox_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aWrEn = 0, aRdEn = 0, bWrEn = 0, bRdEn = 0;
  logic [1:0] aAddr = 0, bAddr = 0;
  logic [31:0] aWrData = 0, bWrData = 0;
  logic [31:0] aRdData, bRdData;
  logic aIrqSendEmpty, aIrqRecvNotEmpty, bIrqSendEmpty, bIrqRecvNotEmpty;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;
  logic [31:0] qAB[$];
  logic [31:0] qBA[$];
  logic [31:0] lastA = 0, lastB = 0;

  always #2 clk = ~clk;

  ipc_mailbox u_ipc_mailbox (
    .clk(clk), .rstN(rstN),
    .aWrEn(aWrEn), .aRdEn(aRdEn), .aAddr(aAddr), .aWrData(aWrData),
    .aRdData(aRdData), .aIrqSendEmpty(aIrqSendEmpty), .aIrqRecvNotEmpty(aIrqRecvNotEmpty),
    .bWrEn(bWrEn), .bRdEn(bRdEn), .bAddr(bAddr), .bWrData(bWrData),
    .bRdData(bRdData), .bIrqSendEmpty(bIrqSendEmpty), .bIrqRecvNotEmpty(bIrqRecvNotEmpty)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busOp(input bit side, input bit wr, input bit rd, input logic [1:0] addr,
                       input logic [31:0] wd, output logic [31:0] rdv);
    @(negedge clk);
    if (!side) begin aWrEn = wr; aRdEn = rd; aAddr = addr; aWrData = wd; end
    else       begin bWrEn = wr; bRdEn = rd; bAddr = addr; bWrData = wd; end
    #1;
    rdv = side ? bRdData : aRdData;
    @(negedge clk);
    aWrEn = 0; aRdEn = 0; bWrEn = 0; bRdEn = 0;
  endtask

  task automatic writeCtrl(input bit side, input logic [31:0] v);
    logic [31:0] dummy;
    busOp(side, 1, 0, 2'd0, v, dummy);
  endtask

  task automatic readCtrl(input bit side, output logic [31:0] v);
    busOp(side, 0, 0, 2'd0, 32'h0, v);
  endtask

  // driver: push a word and record it as expected on the far side
  task automatic pushWord(input bit side, input logic [31:0] d, input bit accept);
    logic [31:0] dummy;
    busOp(side, 1, 0, 2'd1, d, dummy);
    if (accept) begin
      if (!side) qAB.push_back(d); else qBA.push_back(d);
    end
  endtask

  // monitor: pop on the reader side and compare with the scoreboard
  task automatic popWord(input bit side, input string tag);
    logic [31:0] got, exp;
    busOp(side, 0, 1, 2'd2, 32'h0, got);
    if (side) begin
      if (qAB.size() > 0) begin exp = qAB.pop_front(); lastB = exp; end
      else exp = lastB;
    end else begin
      if (qBA.size() > 0) begin exp = qBA.pop_front(); lastA = exp; end
      else exp = lastA;
    end
    check(tag, got, exp);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    readCtrl(0, v); check("R11 A ctrl after reset", v, 32'h0000_0101);
    readCtrl(1, v); check("R11 B ctrl after reset", v, 32'h0000_0101);
    check("R11 irqs after reset",
          {28'h0, aIrqSendEmpty, aIrqRecvNotEmpty, bIrqSendEmpty, bIrqRecvNotEmpty}, 32'h0);

    // R10 push ignored while disabled
    pushWord(0, 32'h0000_0011, 0);
    readCtrl(1, v); check("R10 B rx empty after disabled push", (v >> 8) & 1, 32'd1);
    readCtrl(0, v); check("R10 A tx empty after disabled push", v & 1, 32'd1);

    // enable both sides
    writeCtrl(0, 32'h0000_8004);
    writeCtrl(1, 32'h0000_8400);
    check("R2 A send-empty irq asserted", {31'h0, aIrqSendEmpty}, 32'd1);
    check("R5 B recv irq idle", {31'h0, bIrqRecvNotEmpty}, 32'd0);

    pushWord(0, 32'hDEAD_BEEF, 1);
    pushWord(0, 32'h1234_5678, 1);
    pushWord(0, 32'h8000_0001, 1);
    readCtrl(1, v); check("R4 B ctrl with inbound data", v, 32'h0000_8401);
    check("R2 A send-empty irq drops", {31'h0, aIrqSendEmpty}, 32'd0);
    check("R5 B recv irq asserted", {31'h0, bIrqRecvNotEmpty}, 32'd1);
    for (int i = 0; i < 3; i++) popWord(1, "R6 A to B order");
    check("R5 B recv irq cleared", {31'h0, bIrqRecvNotEmpty}, 32'd0);

    // R8 empty read
    popWord(1, "R8 empty read returns last popped");
    readCtrl(1, v); check("R8 B error latched", v, 32'h0000_C501);
    writeCtrl(1, 32'h0000_8400);
    readCtrl(1, v); check("R9 error survives write of 0", v, 32'h0000_C501);
    writeCtrl(1, 32'h0000_C400);
    readCtrl(1, v); check("R9 error cleared by write of 1", v, 32'h0000_8501);

    // fill to depth
    for (int i = 0; i < 16; i++) pushWord(0, 32'hA500_0000 + 32'(i), 1);
    readCtrl(0, v); check("R1 A tx full", v, 32'h0000_8106);
    readCtrl(1, v); check("R4 B rx full", v, 32'h0000_8601);
    pushWord(0, 32'hFFFF_FFFF, 0);
    readCtrl(0, v); check("R7 overflow sets error", v, 32'h0000_C106);
    for (int i = 0; i < 16; i++) popWord(1, "R7 data after overflow");
    popWord(1, "R8 empty read after drain");

    // R3 flush
    writeCtrl(0, 32'h0000_C004);
    pushWord(0, 32'h0000_00F1, 1);
    pushWord(0, 32'h0000_00F2, 1);
    writeCtrl(0, 32'h0000_800C);
    qAB.delete();
    readCtrl(0, v); check("R3 flush empties A tx", v, 32'h0000_8105);
    readCtrl(1, v); check("R3 B sees empty after flush", (v >> 8) & 1, 32'd1);
    pushWord(0, 32'h0000_00F3, 1);
    writeCtrl(0, 32'h0000_8004);
    readCtrl(0, v); check("R3 write 0 to flush bit keeps data", v & 1, 32'd0);
    popWord(1, "R3 word survives no-op flush");

    // R6 B to A
    writeCtrl(0, 32'h0000_8404);
    pushWord(1, 32'hCAFE_0001, 1);
    pushWord(1, 32'hCAFE_0002, 1);
    check("R5 A recv irq asserted", {31'h0, aIrqRecvNotEmpty}, 32'd1);
    popWord(0, "R6 B to A order");
    popWord(0, "R6 B to A order");

    // R10 pop ignored while disabled
    pushWord(0, 32'h0000_ABCD, 1);
    writeCtrl(1, 32'h0000_0000);
    busOp(1, 0, 1, 2'd2, 32'h0, v);
    readCtrl(1, v); check("R10 disabled pop keeps word", (v >> 8) & 1, 32'd0);
    writeCtrl(1, 32'h0000_8400);
    popWord(1, "R10 word delivered after re-enable");
    readCtrl(1, v); check("R10 B rx empty after pop", (v >> 8) & 1, 32'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule